// File: doc/BRIEF.md
# Redundant-Access Filter with Sleep Sequencing for a Single-Port SRAM

The block sits between one requester and one single-port synchronous SRAM and lowers the memory's power in two ways. First, it keeps the memory enable low whenever an access would change nothing. A read of the address read last time is answered from a register inside the wrapper. A write that repeats the address and data of the previous write is dropped. Second, once the requester has been silent for a set number of cycles, the wrapper puts the memory into its low-leakage sleep state. When a request arrives while the memory is asleep, the wrapper spends one cycle waking it before the request is accepted.

The requester side uses a valid/ready handshake. A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high. Every accepted read produces `rsp_valid` for one cycle, on the cycle after acceptance. This holds whether the data comes from the SRAM or from the held register. Three free-running counters report how many reads were absorbed, how many writes were dropped and how many cycles the memory spent asleep.

Top module: `mem_access_gate`

## Requirements
- R1: An accepted read whose address does not match the valid held read address drives `mem_en`=1, `mem_we`=0 and `mem_addr`=`req_addr` in its acceptance cycle. On the next cycle, `rsp_rdata` carries the SRAM word.
- R2: An accepted read to the held read address, while that entry is valid, keeps `mem_en` at 0. On the next cycle it returns the word captured from the SRAM for that address. The entry survives idle gaps and sleep periods.
- R3: An accepted write that differs in address or data from the last write record drives `mem_en`=1 and `mem_we`=1 with the request's address and data. It then becomes the new write record.
- R4: An accepted write with the same address and data as the last write record keeps `mem_en` and `mem_we` at 0.
- R5: A write that reaches the SRAM at the held read address invalidates the held entry, so the next read of that address goes to the SRAM and returns the new data. A write to any other address leaves the held entry valid.
- R6: After reset, `rsp_valid`=0, `mem_sleep`=0, `req_ready`=1 and all counters read 0. Both the held read entry and the write record are invalid, so the first read and the first write reach the SRAM.
- R7: `mem_sleep` rises at the clock edge that ends the IDLE_LIMIT-th consecutive cycle with `req_valid`=0. Any cycle with `req_valid`=1 restarts the count.
- R8: While `mem_sleep`=1, `req_ready`=0 and `mem_en`=0. A request seen while asleep clears `mem_sleep` at the next edge, which delays acceptance by exactly one cycle.
- R9: `cnt_rd_skip` counts accepted reads served without the SRAM. `cnt_wr_skip` counts dropped writes. `cnt_sleep` counts clock edges at which `mem_sleep` was 1.
- R10: `rsp_valid` is 1 exactly on the cycle after an accepted read and is 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Wrapper can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, valid the cycle after a read |
| mem_sleep | output | 1 | SRAM low-leakage sleep control |
| cnt_rd_skip | output | CNT_W | Reads served without the SRAM |
| cnt_wr_skip | output | CNT_W | Writes dropped as duplicates |
| cnt_sleep | output | CNT_W | Cycles spent asleep |

## Verification
The properties that compare a request with the one before it assume the requester's inputs are settled and known at every rising edge after reset. They also assume `req_valid` is low while reset is asserted, so the cycle just after reset never looks like a repeated access. The bench meets these assumptions in three ways. It holds every input at zero through reset. It changes inputs only on falling edges. It keeps a request's fields unchanged while it waits for `req_ready`, including across the wake cycle. In addition, the SRAM model in the bench answers reads one cycle late, which matches the timing the wrapper expects on `mem_rdata`.

// File: rtl/mem_access_gate.sv
module mem_access_gate #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int IDLE_LIMIT = 16,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_sleep,
  output logic [CNT_W-1:0] cnt_rd_skip,
  output logic [CNT_W-1:0] cnt_wr_skip,
  output logic [CNT_W-1:0] cnt_sleep
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);

  logic          sleep_q;
  logic [IW-1:0] idle_q;
  logic          rd_v_q, rsp_v_q, rsp_mem_q;
  logic [AW-1:0] rd_a_q;
  logic [DW-1:0] hold_q;
  logic          wr_v_q;
  logic [AW-1:0] wr_a_q;
  logic [DW-1:0] wr_d_q;

  logic take_rd, take_wr, rd_hit, wr_dup, rd_go, wr_go, idle_hit;

  assign req_ready = !sleep_q;
  assign take_rd   = req_valid && req_ready && !req_write;
  assign take_wr   = req_valid && req_ready &&  req_write;
  assign rd_hit    = rd_v_q && (req_addr == rd_a_q);
  assign wr_dup    = wr_v_q && (req_addr == wr_a_q) && (req_wdata == wr_d_q);
  assign rd_go     = take_rd && !rd_hit;
  assign wr_go     = take_wr && !wr_dup;
  assign idle_hit  = !req_valid && !sleep_q && (idle_q == IW'(IDLE_LIMIT - 1));

  assign mem_en    = rd_go || wr_go;
  assign mem_we    = wr_go;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign mem_sleep = sleep_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_mem_q ? mem_rdata : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q     <= 1'b0;
      idle_q      <= '0;
      rd_v_q      <= 1'b0;
      rd_a_q      <= '0;
      hold_q      <= '0;
      rsp_v_q     <= 1'b0;
      rsp_mem_q   <= 1'b0;
      wr_v_q      <= 1'b0;
      wr_a_q      <= '0;
      wr_d_q      <= '0;
      cnt_rd_skip <= '0;
      cnt_wr_skip <= '0;
      cnt_sleep   <= '0;
    end else begin
      rsp_v_q   <= take_rd;
      rsp_mem_q <= rd_go;
      if (rsp_mem_q) hold_q <= mem_rdata;

      if (rd_go) begin
        rd_v_q <= 1'b1;
        rd_a_q <= req_addr;
      end else if (wr_go && (req_addr == rd_a_q)) begin
        rd_v_q <= 1'b0;
      end

      if (wr_go) begin
        wr_v_q <= 1'b1;
        wr_a_q <= req_addr;
        wr_d_q <= req_wdata;
      end

      if (req_valid || sleep_q)           idle_q <= '0;
      else if (idle_q != IW'(IDLE_LIMIT)) idle_q <= idle_q + 1'b1;

      if (sleep_q && req_valid) sleep_q <= 1'b0;
      else if (idle_hit)        sleep_q <= 1'b1;

      if (take_rd && rd_hit) cnt_rd_skip <= cnt_rd_skip + 1'b1;
      if (take_wr && wr_dup) cnt_wr_skip <= cnt_wr_skip + 1'b1;
      if (sleep_q)           cnt_sleep   <= cnt_sleep + 1'b1;
    end
  end
endmodule

// File: rtl/mem_access_gate_chk.sv
module mem_access_gate_chk #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic             rsp_valid,
  input logic             mem_en,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_sleep,
  input logic [CNT_W-1:0] cnt_rd_skip,
  input logic [CNT_W-1:0] cnt_sleep
);
  logic acc_rd, acc_wr;
  assign acc_rd = req_valid && req_ready && !req_write;
  assign acc_wr = req_valid && req_ready &&  req_write;

  AST_READ_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && mem_en) |-> (!mem_we && mem_addr == req_addr)); // R1
  AST_REPEAT_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && $past(acc_rd) && req_addr == $past(req_addr)) |-> !mem_en); // R2
  AST_WRITE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && mem_en) |-> (mem_we && mem_addr == req_addr && mem_wdata == req_wdata)); // R3
  AST_REPEAT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && $past(acc_wr) && req_addr == $past(req_addr) && req_wdata == $past(req_wdata)) |-> !mem_en); // R4
  AST_SLEEP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sleep) |-> $past(!req_valid)); // R7
  AST_QUIET_WHILE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sleep |-> (!req_ready && !mem_en)); // R8
  AST_WAKE_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sleep && req_valid) |=> !mem_sleep); // R8
  AST_READ_SKIP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !mem_en) |=> cnt_rd_skip == CNT_W'($past(cnt_rd_skip) + 1'b1)); // R9
  AST_SLEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sleep |=> cnt_sleep == CNT_W'($past(cnt_sleep) + 1'b1)); // R9
  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid); // R10
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_rd)); // R10
endmodule

bind mem_access_gate mem_access_gate_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_sleep(mem_sleep), .cnt_rd_skip(cnt_rd_skip),
  .cnt_sleep(cnt_sleep)
);

// File: tb/tb_mem_access_gate.sv
`timescale 1ns/1ps
module tb_mem_access_gate;
  localparam int AW = 8, DW = 16, LIM = 12, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_en, mem_we, mem_sleep;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] cnt_rd_skip, cnt_wr_skip, cnt_sleep;

  always #5 clk = ~clk;

  mem_access_gate #(.AW(AW), .DW(DW), .IDLE_LIMIT(LIM), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_sleep(mem_sleep), .cnt_rd_skip(cnt_rd_skip), .cnt_wr_skip(cnt_wr_skip),
    .cnt_sleep(cnt_sleep));

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 37 + 11);
  endfunction

  logic [DW-1:0] sram [0:(1<<AW)-1];
  int bad_acc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) sram[i] <= init_word(i);
    end else if (mem_en) begin
      if (mem_sleep) bad_acc <= bad_acc + 1;
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else        mem_rdata <= sram[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic m_rd_v = 1'b0, m_wr_v = 1'b0;
  logic [AW-1:0] m_rd_a = '0, m_wr_a = '0;
  logic [DW-1:0] m_wr_d = '0;
  int exp_rd_skip = 0, exp_wr_skip = 0, exp_sleep = 0;

  logic o_en, o_we, o_rv, e_quiet;
  logic [DW-1:0] o_rd, e_rd;
  int o_waits;

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) e_quiet = m_wr_v && m_wr_a == a && m_wr_d == d;
    else    e_quiet = m_rd_v && m_rd_a == a;
    e_rd = shadow[a];
    o_waits = 0;
    #1;
    while (!req_ready) begin
      o_waits++;
      @(negedge clk);
    end
    o_en = mem_en; o_we = mem_we;
    @(negedge clk);
    o_rv = rsp_valid; o_rd = rsp_rdata;
    if (wr) begin
      shadow[a] = d;
      if (e_quiet) exp_wr_skip++;
      else begin
        m_wr_v = 1'b1; m_wr_a = a; m_wr_d = d;
        if (m_rd_a == a) m_rd_v = 1'b0;
      end
    end else begin
      if (e_quiet) exp_rd_skip++;
      else begin m_rd_v = 1'b1; m_rd_a = a; end
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R6 rsp_valid", rsp_valid, 0);
    chk("R6 mem_sleep", mem_sleep, 0);
    chk("R6 req_ready", req_ready, 1);
    chk("R6 counters", {cnt_rd_skip, cnt_wr_skip} | cnt_sleep, 0);
  endtask

  task automatic t_reads;
    send(1'b0, 8'd5, '0);
    chk("R6 first read reaches SRAM", o_en, 1);
    chk("R1 read miss we", o_we, 0);
    chk("R1 read miss data", o_rd, init_word(5));
    chk("R10 rsp after read", o_rv, 1);
    send(1'b0, 8'd5, '0);
    chk("R2 repeat read quiet", o_en, 0);
    chk("R2 repeat read data", o_rd, init_word(5));
    idle(3);
    send(1'b0, 8'd5, '0);
    chk("R2 hit after gap quiet", o_en, 0);
    chk("R2 hit after gap data", o_rd, init_word(5));
    send(1'b0, 8'd6, '0);
    chk("R1 new address miss", o_en, 1);
    chk("R1 new address data", o_rd, init_word(6));
    idle(1);
  endtask

  task automatic t_writes;
    send(1'b1, 8'd6, 16'hBEEF);
    chk("R6 first write reaches SRAM", o_en, 1);
    chk("R3 write we", o_we, 1);
    chk("R10 no rsp after write", o_rv, 0);
    send(1'b1, 8'd6, 16'hBEEF);
    chk("R4 duplicate write quiet", o_en | o_we, 0);
    send(1'b0, 8'd6, '0);
    chk("R5 read after write reaches SRAM", o_en, 1);
    chk("R5 read after write data", o_rd, 16'hBEEF);
    send(1'b1, 8'd30, 16'h1234);
    chk("R3 other-address write", o_en, 1);
    send(1'b0, 8'd6, '0);
    chk("R5 unrelated write keeps entry", o_en, 0);
    chk("R5 unrelated write data", o_rd, 16'hBEEF);
    send(1'b1, 8'd6, 16'hBEEF);
    chk("R3 record moved, write issued", o_en, 1);
    send(1'b1, 8'd6, 16'hCAFE);
    chk("R3 new data same address", o_en & o_we, 1);
    idle(1);
    chk("R10 idle no rsp", rsp_valid, 0);
  endtask

  task automatic t_sleep;
    send(1'b0, 8'd6, '0);
    chk("R5 read sees CAFE", o_rd, 16'hCAFE);
    idle(LIM - 1);
    chk("R7 awake before limit", mem_sleep, 0);
    send(1'b0, 8'd6, '0);
    idle(LIM - 1);
    chk("R7 request restarts count", mem_sleep, 0);
    idle(1);
    chk("R7 asleep at limit", mem_sleep, 1);
    chk("R8 not ready asleep", req_ready, 0);
    idle(5);
    exp_sleep += 5;
    send(1'b0, 8'd6, '0);
    exp_sleep += 1;
    chk("R8 one wake cycle", o_waits, 1);
    chk("R2 hold survives sleep", o_en, 0);
    chk("R2 hold data after sleep", o_rd, 16'hCAFE);
    send(1'b0, 8'd77, '0);
    chk("R1 miss after wake", o_en, 1);
    chk("R1 miss after wake data", o_rd, init_word(77));
    idle(LIM + 3);
    exp_sleep += 3;
    send(1'b1, 8'd77, 16'h0F0F);
    exp_sleep += 1;
    chk("R8 write wake cycle", o_waits, 1);
    chk("R3 write after wake", o_en, 1);
    idle(1);
    chk("R8 no SRAM access asleep", bad_acc, 0);
  endtask

  task automatic t_counters;
    chk("R9 read skips", cnt_rd_skip, exp_rd_skip);
    chk("R9 write skips", cnt_wr_skip, exp_wr_skip);
    chk("R9 sleep cycles", cnt_sleep, exp_sleep);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_writes();
    t_sleep();
    t_counters();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule